// File: doc/BRIEF.md
# Banked Data Memory Address Resolver

This block sits between a small CPU's operand path and its data storage. For every data access it receives a 7-bit address, a bank select bit and the access kind (read, write, bit operation, or a store to the separate write-only register plane). It decides where the access lands. The possible targets are a special-function register, a byte of the packed physical RAM, or a register of the write-only plane. It can also decide that the access lands nowhere.

Address 0x00 of the main plane is a virtual register. An access to it is redirected to the address held in a pointer register. That pointer register lives in this block as special-function register 4. Its new value applies to the access that follows the write.

The RAM map has three parts. The bytes just above the register file are shared by both banks. The remainder of the lower half is duplicated per bank, and so is the whole upper half. All three parts are packed into one contiguous physical range of 184 bytes. The block also flags requests it will not carry out: bit operations above the lower half, reads of the write-only plane, and write-only-plane stores outside its 32 registers.

Top module: `dmr_resolver`

## Requirements
- R1: An effective address in 0x00-0x1F (other than the direct use of 0x00) asserts sfr_sel with sfr_idx equal to its low 5 bits, and drives no RAM enable.
- R2: Effective addresses 0x20-0x27 map to physical RAM address (ea - 0x20), whatever the bank bit is.
- R3: Effective addresses 0x28-0x3F map to physical address 8 + 24*bank + (ea - 0x28).
- R4: Effective addresses 0x40-0x7F map to physical address 56 + 64*bank + (ea - 0x40), so every RAM address stays below 184.
- R5: A main-plane access with acc_addr = 0x00 uses the pointer value as its effective address, and the mapping of R1-R4 is applied to that value.
- R6: The pointer is SFR index 4. It resets to 0x00. A main-plane write that resolves to it (directly or indirectly) stores wr_data, and the stored value is used from the next access on.
- R7: An indirect access while the pointer holds 0x00 selects nothing and enables nothing. A read raises rd_zero, and a write leaves the pointer and every target unchanged.
- R8: A bit operation whose effective address is 0x40 or above raises illegal and rd_zero on a read, and enables no RAM. Bit operations below 0x40 resolve normally.
- R9: A write-only-plane store (acc_rpl with acc_wr, no acc_rd) to acc_addr below 0x20 pulses rpl_wr with rpl_idx = acc_addr and drives no main-plane output. At 0x20 or above it raises illegal with no strobe.
- R10: A write-only-plane access with acc_rd set raises rd_zero and illegal and issues no strobe of any kind.
- R11: ram_rd follows acc_rd and ram_wr follows acc_wr. With neither requested, every output is zero, and unused index and address outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 7 | Direct address from the instruction |
| acc_rd | input | 1 | Read requested |
| acc_wr | input | 1 | Write requested |
| acc_bit | input | 1 | Access is a bit operation |
| acc_rpl | input | 1 | Access targets the write-only plane |
| bank_sel | input | 1 | Bank select for the duplicated RAM |
| wr_data | input | 7 | Write data as seen by the pointer register |
| sfr_sel | output | 1 | Access lands in a special-function register |
| sfr_idx | output | 5 | Selected special-function register |
| ram_addr | output | 8 | Physical RAM address |
| ram_rd | output | 1 | RAM read enable |
| ram_wr | output | 1 | RAM write enable |
| rpl_wr | output | 1 | Write strobe for the write-only plane |
| rpl_idx | output | 5 | Write-only plane register index |
| rd_zero | output | 1 | Read data must be forced to zero |
| illegal | output | 1 | Request refused |

## Verification
The bench builds the block with its default parameters: a 32-entry register file, 8 shared bytes, 24-byte and 64-byte banked regions, and the virtual register at 0x00. With these values all 128 direct addresses can be swept in both banks. Each of the 128 pointer values can also be loaded and followed through the indirect register. This puts every region edge (0x1F/0x20, 0x27/0x28, 0x3F/0x40) and the top of physical RAM under check. Pointer self-reference, bit operations on both sides of 0x40, and write-only-plane stores on both sides of 0x20 are driven as separate cases.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    typedef enum logic [1:0] {
        RGN_SFR    = 2'd0,
        RGN_SHARED = 2'd1,
        RGN_LOW    = 2'd2,
        RGN_HIGH   = 2'd3
    } dmr_region_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic bitop;
        logic rpl;
    } dmr_acc_t;

    // Region of an effective address given the sizes below the upper half.
    function automatic dmr_region_e region_of(int ea, int sfr_n, int shared_n, int low_n);
        if (ea < sfr_n)                         return RGN_SFR;
        else if (ea < sfr_n + shared_n)         return RGN_SHARED;
        else if (ea < sfr_n + shared_n + low_n) return RGN_LOW;
        else                                    return RGN_HIGH;
    endfunction

endpackage

// File: rtl/dmr_ptr_reg.sv
module dmr_ptr_reg #(
    parameter int W         = 7,
    parameter int RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= W'(RESET_VAL);
        else if (we) q <= din;
    end

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(din))); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q)); // R6

endmodule

// File: rtl/dmr_map.sv
module dmr_map
    import dmr_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int SFR_N     = 32,
    parameter int SHARED_N  = 8,
    parameter int LOW_N     = 24,
    parameter int HIGH_N    = 64,
    parameter int PHYS_W    = 8
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic              bank,
    output dmr_region_e       region,
    output logic [PHYS_W-1:0] phys,
    output logic [$clog2(SFR_N)-1:0] sfr_idx
);
    localparam int SFR_W     = $clog2(SFR_N);
    localparam int LOW_BASE  = SFR_N + SHARED_N;
    localparam int HIGH_BASE = LOW_BASE + LOW_N;
    localparam int LOW_PHYS  = SHARED_N;
    localparam int HIGH_PHYS = SHARED_N + 2 * LOW_N;

    int ea_i;
    int phys_i;

    always_comb begin
        ea_i    = int'(ea);
        region  = region_of(ea_i, SFR_N, SHARED_N, LOW_N);
        sfr_idx = ea[SFR_W-1:0];
        unique case (region)
            RGN_SHARED: phys_i = ea_i - SFR_N;
            RGN_LOW:    phys_i = LOW_PHYS + int'(bank) * LOW_N + (ea_i - LOW_BASE);
            RGN_HIGH:   phys_i = HIGH_PHYS + int'(bank) * HIGH_N + (ea_i - HIGH_BASE);
            default:    phys_i = 0;
        endcase
        phys = PHYS_W'(phys_i);
    end

endmodule

// File: rtl/dmr_gate.sv
module dmr_gate
    import dmr_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int SFR_W  = 5,
    parameter int PHYS_W = 8,
    parameter int RPL_N  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  dmr_acc_t          acc,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic              is_ind,
    input  logic              ptr_null,
    input  dmr_region_e       region,
    input  logic [PHYS_W-1:0] phys,
    input  logic [SFR_W-1:0]  idx_in,
    output logic              sfr_sel,
    output logic [SFR_W-1:0]  sfr_idx,
    output logic [PHYS_W-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic              rpl_wr,
    output logic [$clog2(RPL_N)-1:0] rpl_idx,
    output logic              rd_zero,
    output logic              illegal
);
    localparam int RPL_W = $clog2(RPL_N);

    logic f_acc, bit_bad, null_tgt, ok, rpl_in_range, ram_hit;

    always_comb begin
        f_acc        = !acc.rpl && (acc.rd || acc.wr);
        bit_bad      = f_acc && acc.bitop && (region == RGN_HIGH);
        null_tgt     = f_acc && is_ind && ptr_null;
        ok           = f_acc && !bit_bad && !null_tgt;
        rpl_in_range = int'(dir_addr) < RPL_N;

        sfr_sel  = ok && (region == RGN_SFR);
        ram_hit  = ok && (region != RGN_SFR);
        ram_rd   = ram_hit && acc.rd;
        ram_wr   = ram_hit && acc.wr;
        sfr_idx  = sfr_sel ? idx_in : '0;
        ram_addr = ram_hit ? phys : '0;

        rpl_wr   = acc.rpl && acc.wr && !acc.rd && rpl_in_range;
        rpl_idx  = rpl_wr ? dir_addr[RPL_W-1:0] : '0;

        rd_zero  = acc.rd && (null_tgt || bit_bad || acc.rpl);
        illegal  = bit_bad || (acc.rpl && acc.rd)
                 || (acc.rpl && acc.wr && !rpl_in_range);
    end

    AST_NULL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (is_ind && ptr_null && !acc.rpl) |-> !(sfr_sel || ram_rd || ram_wr)); // R7
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(ram_wr || rpl_wr)); // R8
    AST_RPL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        rpl_wr |-> !(sfr_sel || ram_rd || ram_wr)); // R9
    AST_RPL_READ: assert property (@(posedge clk) disable iff (rst)
        (acc.rpl && acc.rd) |-> (rd_zero && illegal && !rpl_wr)); // R10
    AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
        (ram_wr |-> acc.wr) and (ram_rd |-> acc.rd)); // R11

endmodule

// File: rtl/dmr_resolver.sv
module dmr_resolver
    import dmr_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int SFR_N    = 32,
    parameter int SHARED_N = 8,
    parameter int LOW_N    = 24,
    parameter int HIGH_N   = 64,
    parameter int RPL_N    = 32,
    parameter int IND_ADDR = 0,
    parameter int PTR_IDX  = 4,
    localparam int SFR_W      = $clog2(SFR_N),
    localparam int RPL_W      = $clog2(RPL_N),
    localparam int PHYS_TOTAL = SHARED_N + 2 * LOW_N + 2 * HIGH_N,
    localparam int PHYS_W     = $clog2(PHYS_TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              acc_bit,
    input  logic              acc_rpl,
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              sfr_sel,
    output logic [SFR_W-1:0]  sfr_idx,
    output logic [PHYS_W-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic              rpl_wr,
    output logic [RPL_W-1:0]  rpl_idx,
    output logic              rd_zero,
    output logic              illegal
);
    localparam int HIGH_PHYS = SHARED_N + 2 * LOW_N;

    dmr_acc_t          acc;
    logic [ADDR_W-1:0] ptr_q, ea;
    logic              is_ind, ptr_null, ptr_we;
    dmr_region_e       region;
    logic [PHYS_W-1:0] phys;
    logic [SFR_W-1:0]  map_idx;

    assign acc      = '{rd: acc_rd, wr: acc_wr, bitop: acc_bit, rpl: acc_rpl};
    assign is_ind   = (int'(acc_addr) == IND_ADDR);
    assign ptr_null = (int'(ptr_q) == IND_ADDR);
    assign ea       = is_ind ? ptr_q : acc_addr;
    assign ptr_we   = sfr_sel && acc_wr && (int'(sfr_idx) == PTR_IDX);

    dmr_ptr_reg #(.W(ADDR_W), .RESET_VAL(0)) u_ptr (
        .clk(clk), .rst(rst), .we(ptr_we), .din(wr_data), .q(ptr_q)
    );

    dmr_map #(
        .ADDR_W(ADDR_W), .SFR_N(SFR_N), .SHARED_N(SHARED_N),
        .LOW_N(LOW_N), .HIGH_N(HIGH_N), .PHYS_W(PHYS_W)
    ) u_map (
        .ea(ea), .bank(bank_sel), .region(region), .phys(phys), .sfr_idx(map_idx)
    );

    dmr_gate #(
        .ADDR_W(ADDR_W), .SFR_W(SFR_W), .PHYS_W(PHYS_W), .RPL_N(RPL_N)
    ) u_gate (
        .clk(clk), .rst(rst), .acc(acc), .dir_addr(acc_addr),
        .is_ind(is_ind), .ptr_null(ptr_null), .region(region), .phys(phys),
        .idx_in(map_idx), .sfr_sel(sfr_sel), .sfr_idx(sfr_idx),
        .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .rpl_wr(rpl_wr), .rpl_idx(rpl_idx), .rd_zero(rd_zero), .illegal(illegal)
    );

    AST_SFR_NO_RAM: assert property (@(posedge clk) disable iff (rst)
        sfr_sel |-> !(ram_rd || ram_wr)); // R1
    AST_RAM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ram_rd || ram_wr) |-> (int'(ram_addr) < PHYS_TOTAL)); // R4
    AST_BIT_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (acc_bit && (ram_rd || ram_wr)) |-> (int'(ram_addr) < HIGH_PHYS)); // R8

endmodule

// File: tb/tb_dmr_resolver.sv
module tb_dmr_resolver;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] acc_addr = '0;
    logic       acc_rd = 0, acc_wr = 0, acc_bit = 0, acc_rpl = 0, bank_sel = 0;
    logic [6:0] wr_data = '0;
    logic       sfr_sel, ram_rd, ram_wr, rpl_wr, rd_zero, illegal;
    logic [4:0] sfr_idx, rpl_idx;
    logic [7:0] ram_addr;

    always #5 clk = ~clk;

    dmr_resolver dut (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_rd(acc_rd),
        .acc_wr(acc_wr), .acc_bit(acc_bit), .acc_rpl(acc_rpl),
        .bank_sel(bank_sel), .wr_data(wr_data), .sfr_sel(sfr_sel),
        .sfr_idx(sfr_idx), .ram_addr(ram_addr), .ram_rd(ram_rd),
        .ram_wr(ram_wr), .rpl_wr(rpl_wr), .rpl_idx(rpl_idx),
        .rd_zero(rd_zero), .illegal(illegal)
    );

    typedef struct {
        logic [23:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 0;
    logic [6:0] ptr_m = 7'h00;

    // {sfr_sel, sfr_idx, ram_addr, ram_rd, ram_wr, rpl_wr, rpl_idx, rd_zero, illegal}
    function automatic logic [23:0] expect_of(logic [6:0] a, logic rd, logic wr,
                                              logic bt, logic rp, logic bk, logic [6:0] p);
        logic       s = 0, rr = 0, rw = 0, pw = 0, z = 0, il = 0;
        logic [4:0] si = 0, pi = 0;
        int         pa = 0;
        logic [6:0] e;
        e = (a == 7'h00) ? p : a;
        if (rp) begin
            if (rd) begin z = 1; il = 1; end
            else if (wr) begin
                if (a < 7'h20) begin pw = 1; pi = a[4:0]; end
                else il = 1;
            end
        end else if (rd || wr) begin
            if (a == 7'h00 && p == 7'h00) z = rd;
            else if (bt && e >= 7'h40) begin il = 1; z = rd; end
            else if (e < 7'h20) begin s = 1; si = e[4:0]; end
            else begin
                rr = rd; rw = wr;
                if (e < 7'h28)      pa = int'(e) - 32;
                else if (e < 7'h40) pa = (bk ? 32 : 8) + int'(e) - 40;
                else                pa = (bk ? 120 : 56) + int'(e) - 64;
            end
        end
        return {s, si, 8'(pa), rr, rw, pw, pi, z, il};
    endfunction

    task automatic drive(input logic [6:0] a, input logic rd, input logic wr,
                         input logic bt, input logic rp, input logic bk,
                         input logic [6:0] d, input string tag);
        item_t it;
        logic [6:0] e;
        @(negedge clk);
        acc_addr = a; acc_rd = rd; acc_wr = wr; acc_bit = bt;
        acc_rpl = rp; bank_sel = bk; wr_data = d;
        it.exp = expect_of(a, rd, wr, bt, rp, bk, ptr_m);
        it.tag = tag;
        q.push_back(it);
        e = (a == 7'h00) ? ptr_m : a;
        if (!rp && wr && e == 7'h04 && !(a == 7'h00 && ptr_m == 7'h00)) ptr_m = d;
    endtask

    function automatic string region_tag(logic [6:0] e);
        if (e < 7'h20)      return "R1";
        else if (e < 7'h28) return "R2";
        else if (e < 7'h40) return "R3";
        else                return "R4";
    endfunction

    // Monitor: compares mid-cycle, well away from the rising edge.
    always @(negedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            logic [23:0] got;
            it  = q.pop_front();
            got = {sfr_sel, sfr_idx, ram_addr, ram_rd, ram_wr, rpl_wr, rpl_idx, rd_zero, illegal};
            n_checks++;
            if (got !== it.exp) begin
                n_errors++;
                $display("FAIL %s: addr=%02h got=%06h expected=%06h",
                         it.tag, acc_addr, got, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        drive(7'h00, 0, 0, 0, 0, 0, 7'h00, "R11");            // idle after reset
        drive(7'h00, 1, 0, 0, 0, 0, 7'h00, "R6");             // pointer resets to 0x00
        drive(7'h33, 0, 0, 0, 0, 1, 7'h00, "R11");            // no request
        for (int bk = 0; bk < 2; bk++)
            for (int a = 1; a < 128; a++)
                drive(7'(a), 1, 0, 0, 0, 1'(bk), 7'h00, region_tag(7'(a)));
        for (int a = 1; a < 128; a++)
            if (a != 4) drive(7'(a), 0, 1, 0, 0, 1'(a & 1), 7'h11, region_tag(7'(a)));
        for (int bk = 0; bk < 2; bk++)
            for (int p = 1; p < 128; p++) begin
                drive(7'h04, 0, 1, 0, 0, 1'(bk), 7'(p), "R6");
                drive(7'h00, 1, 0, 0, 0, 1'(bk), 7'h00, "R5");
            end
        // indirect write to the pointer itself
        drive(7'h04, 0, 1, 0, 0, 0, 7'h04, "R6");
        drive(7'h00, 0, 1, 0, 0, 0, 7'h50, "R6");
        drive(7'h00, 1, 0, 0, 0, 1, 7'h00, "R6");
        // self-referencing pointer
        drive(7'h04, 0, 1, 0, 0, 0, 7'h00, "R6");
        drive(7'h00, 0, 1, 0, 0, 0, 7'h2A, "R7");
        drive(7'h00, 1, 0, 0, 0, 0, 7'h00, "R7");
        drive(7'h00, 1, 1, 1, 0, 1, 7'h00, "R7");
        // bit operations
        drive(7'h40, 1, 1, 1, 0, 0, 7'h00, "R8");
        drive(7'h7F, 1, 1, 1, 0, 1, 7'h00, "R8");
        drive(7'h3F, 1, 1, 1, 0, 1, 7'h00, "R8");
        drive(7'h05, 1, 1, 1, 0, 0, 7'h00, "R8");
        drive(7'h04, 0, 1, 0, 0, 0, 7'h45, "R8");
        drive(7'h00, 1, 1, 1, 0, 0, 7'h00, "R8");
        drive(7'h00, 1, 0, 0, 0, 0, 7'h00, "R5");
        // write-only plane
        drive(7'h00, 0, 1, 0, 1, 0, 7'h00, "R9");
        drive(7'h1F, 0, 1, 0, 1, 1, 7'h00, "R9");
        drive(7'h20, 0, 1, 0, 1, 0, 7'h00, "R9");
        drive(7'h04, 0, 1, 0, 1, 0, 7'h00, "R9");
        drive(7'h00, 1, 0, 0, 0, 0, 7'h00, "R9");  // pointer untouched by plane store
        drive(7'h05, 1, 0, 0, 1, 0, 7'h00, "R10");
        drive(7'h05, 1, 1, 0, 1, 0, 7'h00, "R10");
        drive(7'h10, 0, 0, 0, 0, 0, 7'h00, "R11");
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule